// File: doc/BRIEF.md
# Receive Path Anticlipping Gain Controller

The controller sits in a receive audio path after the expander and handles 14-bit signed linear samples that arrive on a strobe at the 8 kHz frame rate. For each sample it takes the magnitude of the incoming value and compares it with one of four programmable peak thresholds. A sample above the threshold raises a digital attenuation by one 1 dB step at once. The raised attenuation also applies to that same sample.

While no sample crosses the threshold, the attenuation falls back by one step at the end of each release interval. A prescaler sets that interval by counting sample strobes. A 2-bit select gives it four lengths. Every strobe returns the scaled sample and the current attenuation.

The controller acts only when the high-gain loudspeaker input is set. With that input low, the attenuation is held at 0 dB and every sample passes through unchanged.

Top module: `anticlip_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released with no strobe, atten_o is 0 and sample_vld_o is 0.
- R2: A sample exceeds the threshold when its magnitude is strictly greater than the limit chosen by thr_sel_i: 0→1012, 1→1274, 2→2019, 3→2542. A value equal to the limit does not exceed it.
- R3: Each strobe in high-gain mode whose sample exceeds the threshold raises atten_o by exactly 1, visible in the cycle after the strobe edge. The new attenuation scales that same sample.
- R4: atten_o never exceeds 12. An exceeding sample at 12 leaves it at 12.
- R5: The prescaler counts strobes in high-gain mode. Its length N is set by rel_sel_i: 0→2000, 1→1000, 2→258, 3→129. On every N-th strobe it restarts and lowers atten_o by 1, but only if no sample in that interval (this strobe included) exceeded the threshold.
- R6: atten_o never goes below 0. A release at 0 leaves it at 0.
- R7: One cycle after a strobe, sample_vld_o is 1 and sample_o = floor(sample_i × G[a] / 32768), where a is the new attenuation. G[0..12] = 32768, 29205, 26029, 23198, 20675, 18427, 16423, 14637, 13045, 11627, 10362, 9235, 8231.
- R8: While high_gain_i is 0, atten_o is 0, the prescaler and the interval flag are cleared, and sample_o equals the strobed sample_i.
- R9: The threshold decision uses the incoming sample, not the scaled output. At a nonzero attenuation, a sample above the threshold still raises the attenuation even when its scaled value lies below the threshold.
- R10: Cycles without a strobe leave atten_o unchanged and hold sample_vld_o at 0, whatever is on sample_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Strobe marking a new input sample |
| sample_i | input | 14 | Signed linear input sample |
| high_gain_i | input | 1 | High-gain loudspeaker mode; enables the limiter |
| thr_sel_i | input | 2 | Threshold select |
| rel_sel_i | input | 2 | Release rate select |
| sample_o | output | 14 | Scaled signed output sample |
| sample_vld_o | output | 1 | Output strobe, one cycle after the input strobe |
| atten_o | output | 4 | Current attenuation in 1 dB steps |

## Verification
Every result is due one clock after the edge that takes the strobe. The attenuation, the scaled sample and the output strobe are all registered once.

The bench applies each strobe at a falling edge and drops it at the next falling edge. It reads all outputs at that second falling edge, where the values from the intervening rising edge are settled.

Release steps are due on exactly the N-th strobe of an interval. The bench numbers its strobes from reset and checks the attenuation one strobe before and on the predicted strobe.

// File: rtl/anticlip_pkg.sv
package anticlip_pkg;

  localparam int BASE_W = 14;
  localparam int GAIN_FRAC = 15;
  localparam int GAIN_W = GAIN_FRAC + 1;

  // peak limits for a 14-bit sample, one per threshold select
  function automatic logic [BASE_W-1:0] thr_base(input logic [1:0] sel);
    case (sel)
      2'd0:    thr_base = 14'd1012;
      2'd1:    thr_base = 14'd1274;
      2'd2:    thr_base = 14'd2019;
      default: thr_base = 14'd2542;
    endcase
  endfunction

  // unsigned Q1.15 gain for an attenuation of k dB
  function automatic logic [GAIN_W-1:0] gain_of(input int unsigned k);
    case (k)
      0:       gain_of = 16'd32768;
      1:       gain_of = 16'd29205;
      2:       gain_of = 16'd26029;
      3:       gain_of = 16'd23198;
      4:       gain_of = 16'd20675;
      5:       gain_of = 16'd18427;
      6:       gain_of = 16'd16423;
      7:       gain_of = 16'd14637;
      8:       gain_of = 16'd13045;
      9:       gain_of = 16'd11627;
      10:      gain_of = 16'd10362;
      11:      gain_of = 16'd9235;
      default: gain_of = 16'd8231;
    endcase
  endfunction

endpackage

// File: rtl/anticlip_detect.sv
module anticlip_detect #(
  parameter int SAMPLE_W = 14
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]          thr_sel_i,
  output logic                over_o
);
  import anticlip_pkg::*;

  localparam int SHIFT = SAMPLE_W - BASE_W;

  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] thr;

  always_comb begin
    // -min wraps to 2^(W-1), which is the correct unsigned magnitude
    mag = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
    thr = SAMPLE_W'(thr_base(thr_sel_i)) << SHIFT;
    over_o = mag > thr;
  end

endmodule

// File: rtl/anticlip_rel_timer.sv
module anticlip_rel_timer #(
  parameter int DIV0 = 2000,
  parameter int DIV1 = 1000,
  parameter int DIV2 = 258,
  parameter int DIV3 = 129,
  parameter int CNT_W = $clog2(DIV0 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic       high_gain_i,
  input  logic       over_i,
  input  logic [1:0] rel_sel_i,
  output logic       release_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             hit_q, hit_d;
  logic             expire;

  always_comb begin
    case (rel_sel_i)
      2'd0:    last = CNT_W'(DIV0 - 1);
      2'd1:    last = CNT_W'(DIV1 - 1);
      2'd2:    last = CNT_W'(DIV2 - 1);
      default: last = CNT_W'(DIV3 - 1);
    endcase
    // >= so a shorter select taken mid-interval still expires
    expire    = vld_i && high_gain_i && (cnt_q >= last);
    release_o = expire && !(hit_q || over_i);
    cnt_d = cnt_q;
    hit_d = hit_q;
    if (!high_gain_i) begin
      cnt_d = '0;
      hit_d = 1'b0;
    end else if (vld_i) begin
      cnt_d = expire ? '0 : cnt_q + 1'b1;
      hit_d = expire ? 1'b0 : (hit_q || over_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(DIV0)); // R5
  AST_HIT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> !release_o); // R5

endmodule

// File: rtl/anticlip_atten.sv
module anticlip_atten #(
  parameter int ATT_MAX = 12,
  parameter int ATT_W = $clog2(ATT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             high_gain_i,
  input  logic             over_i,
  input  logic             release_i,
  output logic [ATT_W-1:0] att_d_o,
  output logic [ATT_W-1:0] att_q_o
);

  logic [ATT_W-1:0] att_q, att_d;

  always_comb begin
    att_d = att_q;
    if (!high_gain_i) begin
      att_d = '0;
    end else if (vld_i) begin
      if (over_i) begin
        if (att_q < ATT_W'(ATT_MAX)) att_d = att_q + 1'b1;
      end else if (release_i && (att_q != '0)) begin
        att_d = att_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) att_q <= '0;
    else         att_q <= att_d;
  end

  assign att_d_o = att_d;
  assign att_q_o = att_q;

  AST_ATT_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= ATT_W'(ATT_MAX)); // R4
  AST_ATTACK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && high_gain_i && over_i && att_q < ATT_W'(ATT_MAX))
      |=> att_q == $past(att_q) + ATT_W'(1)); // R3
  AST_QUIET_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && high_gain_i && !over_i) |=> att_q <= $past(att_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && high_gain_i) |=> $stable(att_q)); // R10

endmodule

// File: rtl/anticlip_scale.sv
module anticlip_scale #(
  parameter int SAMPLE_W = 14,
  parameter int ATT_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [ATT_W-1:0]    att_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                vld_o
);
  import anticlip_pkg::*;

  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [GAIN_W:0]   gain_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    gain_s  = $signed({1'b0, gain_of(int'(att_i))});
    prod    = PROD_W'($signed(sample_i)) * PROD_W'(gain_s);
    shifted = prod >>> GAIN_FRAC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) sample_o <= shifted[SAMPLE_W-1:0];
    end
  end

  AST_VLD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> vld_o == $past(vld_i)); // R7
  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && att_i == '0) |=> sample_o == $past(sample_i)); // R8

endmodule

// File: rtl/anticlip_ctrl.sv
module anticlip_ctrl #(
  parameter int SAMPLE_W = 14,
  parameter int ATT_MAX = 12,
  parameter int REL_DIV0 = 2000,
  parameter int REL_DIV1 = 1000,
  parameter int REL_DIV2 = 258,
  parameter int REL_DIV3 = 129,
  localparam int ATT_W = $clog2(ATT_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                high_gain_i,
  input  logic [1:0]          thr_sel_i,
  input  logic [1:0]          rel_sel_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic [ATT_W-1:0]    atten_o
);

  logic             over, over_hg, rel;
  logic [ATT_W-1:0] att_d;

  anticlip_detect #(.SAMPLE_W(SAMPLE_W)) u_detect (
    .sample_i (sample_i),
    .thr_sel_i(thr_sel_i),
    .over_o   (over)
  );

  assign over_hg = over && high_gain_i;

  anticlip_rel_timer #(
    .DIV0(REL_DIV0), .DIV1(REL_DIV1), .DIV2(REL_DIV2), .DIV3(REL_DIV3)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (sample_vld_i),
    .high_gain_i(high_gain_i),
    .over_i     (over_hg),
    .rel_sel_i  (rel_sel_i),
    .release_o  (rel)
  );

  anticlip_atten #(.ATT_MAX(ATT_MAX)) u_atten (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (sample_vld_i),
    .high_gain_i(high_gain_i),
    .over_i     (over_hg),
    .release_i  (rel),
    .att_d_o    (att_d),
    .att_q_o    (atten_o)
  );

  anticlip_scale #(.SAMPLE_W(SAMPLE_W), .ATT_W(ATT_W)) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (sample_vld_i),
    .sample_i(sample_i),
    .att_i   (att_d),
    .sample_o(sample_o),
    .vld_o   (sample_vld_o)
  );

  AST_LOW_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !high_gain_i |=> atten_o == '0); // R8
  AST_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(atten_o) == '0 && !over_hg) |-> atten_o == '0); // R6

endmodule

// File: tb/sim_anticlip_ctrl.sv
`timescale 1ns/1ps
module sim_anticlip_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [13:0] smp = '0;
  logic        hg = 1'b0;
  logic [1:0]  thr = '0;
  logic [1:0]  rsel = '0;
  logic [13:0] smp_o;
  logic        vld_o;
  logic [3:0]  att_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_smp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  anticlip_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .sample_i(smp),
    .high_gain_i(hg), .thr_sel_i(thr), .rel_sel_i(rsel),
    .sample_o(smp_o), .sample_vld_o(vld_o), .atten_o(att_o)
  );

  int gtab [0:12] = '{32768, 29205, 26029, 23198, 20675, 18427, 16423,
                      14637, 13045, 11627, 10362, 9235, 8231};

  // {hg, thr_sel, sample, expected attenuation}
  localparam int NV = 20;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {1'b1, 2'd0, 14'sd1012,  4'd0},
    {1'b1, 2'd0, 14'sd1013,  4'd1},
    {1'b1, 2'd0, -14'sd1013, 4'd2},
    {1'b1, 2'd3, 14'sd2542,  4'd2},
    {1'b1, 2'd3, -14'sd2543, 4'd3},
    {1'b1, 2'd1, 14'sd1275,  4'd4},
    {1'b1, 2'd1, 14'sd1274,  4'd4},
    {1'b1, 2'd2, 14'sd2020,  4'd5},
    {1'b1, 2'd2, 14'sd2019,  4'd5},
    {1'b1, 2'd0, 14'sd8191,  4'd6},
    {1'b1, 2'd0, -14'sd8192, 4'd7},
    {1'b1, 2'd0, 14'sd1100,  4'd8},
    {1'b1, 2'd0, 14'sd5000,  4'd9},
    {1'b1, 2'd0, 14'sd5000,  4'd10},
    {1'b1, 2'd0, 14'sd5000,  4'd11},
    {1'b1, 2'd0, 14'sd5000,  4'd12},
    {1'b1, 2'd0, 14'sd5000,  4'd12},
    {1'b0, 2'd0, 14'sd5000,  4'd0},
    {1'b1, 2'd0, 14'sd100,   4'd0},
    {1'b1, 2'd0, -14'sd1013, 4'd1}
  };

  function automatic int exp_out(int x, int k);
    longint p;
    p = longint'(x) * longint'(gtab[k]);
    return int'(p >>> 15);
  endfunction

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(int x);
    @(negedge clk);
    vld = 1'b1;
    smp = 14'(x);
    @(negedge clk);
    vld = 1'b0;
    n_smp++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n_smp = 0;
  endtask

  task automatic send_to(int last, int x);
    while (n_smp < last) send(x);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 atten in reset", int'(att_o), 0);
    check("R1 vld in reset", int'(vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 atten after reset", int'(att_o), 0);
    check("R1 vld after reset", int'(vld_o), 0);

    // table walk: R2 R3 R4 R7 R8 R9
    rsel = 2'd0;
    for (int i = 0; i < NV; i++) begin
      hg  = VEC[i][20];
      thr = VEC[i][19:18];
      send(int'($signed(VEC[i][17:4])));
      check($sformatf("R2/R3/R4/R9 vec%0d atten", i), int'(att_o), int'(VEC[i][3:0]));
      check($sformatf("R7/R8 vec%0d sample", i), int'($signed(smp_o)),
            exp_out(int'($signed(VEC[i][17:4])), int'(VEC[i][3:0])));
      check($sformatf("R7 vec%0d vld", i), int'(vld_o), 1);
    end

    // R10: no strobe, large value on the bus
    @(negedge clk);
    smp = 14'sd5000;
    repeat (3) @(negedge clk);
    check("R10 atten held", int'(att_o), 1);
    check("R10 no output strobe", int'(vld_o), 0);

    // R5 R6: release at the 129-sample interval
    do_reset();
    hg = 1'b1; thr = 2'd0; rsel = 2'd3;
    send_to(3, 5000);
    check("R3 attack to 3", int'(att_o), 3);
    send_to(129, 10);
    check("R5 first interval blocked", int'(att_o), 3);
    send_to(257, 10);
    check("R5 before release", int'(att_o), 3);
    send(10);
    check("R5 release at 258", int'(att_o), 2);
    check("R7 sample at release", int'($signed(smp_o)), exp_out(10, 2));
    send_to(387, 10);
    check("R5 release at 387", int'(att_o), 1);
    send_to(516, -10);
    check("R5 release at 516", int'(att_o), 0);
    send_to(645, 10);
    check("R6 floor at 0", int'(att_o), 0);

    // R5: an over sample inside the interval blocks its release
    do_reset();
    hg = 1'b1; thr = 2'd0; rsel = 2'd2;
    send_to(2, 5000);
    send_to(399, 10);
    check("R5 no release at 258", int'(att_o), 2);
    send(2000);
    check("R3 attack mid interval", int'(att_o), 3);
    send_to(516, 10);
    check("R5 blocked at 516", int'(att_o), 3);
    send_to(773, 10);
    check("R5 held at 773", int'(att_o), 3);
    send(10);
    check("R5 release at 774", int'(att_o), 2);

    // R5: slowest rate
    do_reset();
    hg = 1'b1; thr = 2'd1; rsel = 2'd0;
    send(1300);
    send_to(3999, 20);
    check("R5 slow held at 3999", int'(att_o), 1);
    send(20);
    check("R5 slow release at 4000", int'(att_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule